// File: doc/BRIEF.md
# Recent-Write Physical Address Cache

This block keeps a small table of the sectors written most recently, each with the physical block and page that now holds its data. A block-mapped flash translation layer asks it about a sector before a host read, and before each page fetch during a fold. On a hit, the controller goes straight to the page it is given and skips the backward walk over the replacement block's spare-area records. On a miss, the controller does that walk as it would without the cache.

Each completed page write loads the table. A lookup that misses never adds an entry. Every entry is a copy of a mapping that the flash already stores, so nothing is ever written back, and losing the contents costs only speed. When a virtual block is folded or erased, the controller names it on the invalidate port, and every entry for a sector of that block is dropped. A new entry replaces whatever the round-robin pointer selects. The number of entries is a parameter.

Top module: `rwc_cache`

## Requirements
- R1: After reset every entry is empty, and `lk_valid` and `lk_hit` are 0.
- R2: `lk_valid` is 1 exactly in the cycle after a cycle with `lk_req` high. In any other cycle it is 0.
- R3: A lookup of a sector whose latest fill is still held returns `lk_hit`=1 with the block and page from that fill.
- R4: A lookup of a sector that is not held returns `lk_hit`=0, with `lk_block` and `lk_page` both 0.
- R5: A fill for a sector that is already held overwrites that entry's block and page. It does not use a new entry, and it does not move the replacement pointer.
- R6: A fill for a sector that is not held goes to the entry under the round-robin pointer, even if other entries are empty. The pointer then steps to the next entry, wrapping from ENTRIES-1 to 0. With ENTRIES entries, the entry filled ENTRIES allocations earlier is the one replaced.
- R7: An invalidate drops every entry whose sector satisfies sector[SECTOR_W-1:PAGE_BITS] == `inv_vblock`. Entries for other virtual blocks are kept.
- R8: When a fill and a lookup name the same sector in the same cycle, the lookup returns the address from that fill.
- R9: Within one cycle, the invalidate takes effect first and the fill second. A lookup in that cycle sees the table after both.
- R10: No two valid entries ever hold the same sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_sector | input | SECTOR_W | Sector to look up |
| fill_en | input | 1 | A page write has completed |
| fill_sector | input | SECTOR_W | Sector that was written |
| fill_block | input | BLOCK_W | Physical block that received the write |
| fill_page | input | PAGE_BITS | Physical page that received the write |
| inv_en | input | 1 | Fold or erase of a virtual block |
| inv_vblock | input | SECTOR_W-PAGE_BITS | Virtual block to drop |
| lk_valid | output | 1 | Lookup result is present |
| lk_hit | output | 1 | Sector was found |
| lk_block | output | BLOCK_W | Physical block on a hit, 0 on a miss |
| lk_page | output | PAGE_BITS | Physical page on a hit, 0 on a miss |

## Verification
The assertions assume that every input holds a known value in every cycle after reset, including the address inputs while their enable is low. They also assume that lookup, fill and invalidate can arrive together in any combination, so none of them rely on the three being kept apart. The stimulus keeps to this by driving every input in every cycle from a fixed-seed generator. Sectors are drawn from a narrow range of four virtual blocks, so in-place rewrites, evictions, same-cycle collisions and invalidates that hit live entries all occur often.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
    localparam int DEF_SECTOR_W  = 16;
    localparam int DEF_PAGE_BITS = 5;
    localparam int DEF_BLOCK_W   = 12;
    localparam int DEF_ENTRIES   = 8;
endpackage

// File: rtl/rwc_match.sv
module rwc_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |hit_vec;
endmodule

// File: rtl/rwc_inval.sv
module rwc_inval #(
    parameter int ENTRIES   = 8,
    parameter int SECTOR_W  = 16,
    parameter int PAGE_BITS = 5,
    localparam int VB_W     = SECTOR_W - PAGE_BITS
) (
    input  logic [ENTRIES-1:0]               valid_in,
    input  logic [ENTRIES-1:0][SECTOR_W-1:0] tags,
    input  logic                             inv_en,
    input  logic [VB_W-1:0]                  inv_vblock,
    output logic [ENTRIES-1:0]               valid_out
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_keep
        assign valid_out[g] = valid_in[g] &&
            !(inv_en && (tags[g][SECTOR_W-1:PAGE_BITS] == inv_vblock));
    end
endmodule

// File: rtl/rwc_rr_ptr.sv
module rwc_rr_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/rwc_cache.sv
module rwc_cache #(
    parameter int SECTOR_W  = rwc_pkg::DEF_SECTOR_W,
    parameter int PAGE_BITS = rwc_pkg::DEF_PAGE_BITS,
    parameter int BLOCK_W   = rwc_pkg::DEF_BLOCK_W,
    parameter int ENTRIES   = rwc_pkg::DEF_ENTRIES,
    localparam int VB_W     = SECTOR_W - PAGE_BITS,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_req,
    input  logic [SECTOR_W-1:0]  lk_sector,
    input  logic                 fill_en,
    input  logic [SECTOR_W-1:0]  fill_sector,
    input  logic [BLOCK_W-1:0]   fill_block,
    input  logic [PAGE_BITS-1:0] fill_page,
    input  logic                 inv_en,
    input  logic [VB_W-1:0]      inv_vblock,
    output logic                 lk_valid,
    output logic                 lk_hit,
    output logic [BLOCK_W-1:0]   lk_block,
    output logic [PAGE_BITS-1:0] lk_page
);
    typedef struct packed {
        logic [ENTRIES-1:0]                valid;
        logic [ENTRIES-1:0][SECTOR_W-1:0]  tag;
        logic [ENTRIES-1:0][BLOCK_W-1:0]   blk;
        logic [ENTRIES-1:0][PAGE_BITS-1:0] pg;
    } table_t;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic [BLOCK_W-1:0]   blk;
        logic [PAGE_BITS-1:0] pg;
    } result_t;

    table_t  tbl_d, tbl_q;
    result_t res_d, res_q;

    logic [ENTRIES-1:0] kept_valid;
    logic               fill_hit;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   rr_ptr;
    logic               rr_adv;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;

    // invalidate is applied before the fill is placed
    rwc_inval #(
        .ENTRIES(ENTRIES), .SECTOR_W(SECTOR_W), .PAGE_BITS(PAGE_BITS)
    ) u_inval (
        .valid_in  (tbl_q.valid),
        .tags      (tbl_q.tag),
        .inv_en    (inv_en),
        .inv_vblock(inv_vblock),
        .valid_out (kept_valid)
    );

    rwc_match #(.ENTRIES(ENTRIES), .TAG_W(SECTOR_W)) u_fill_match (
        .valid(kept_valid),
        .tags (tbl_q.tag),
        .key  (fill_sector),
        .any  (fill_hit),
        .idx  (fill_idx)
    );

    assign rr_adv = fill_en && !fill_hit;

    rwc_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (rr_adv),
        .ptr  (rr_ptr)
    );

    always_comb begin
        tbl_d       = tbl_q;
        tbl_d.valid = kept_valid;
        if (fill_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == (fill_hit ? fill_idx : rr_ptr)) begin
                    tbl_d.valid[i] = 1'b1;
                    tbl_d.tag[i]   = fill_sector;
                    tbl_d.blk[i]   = fill_block;
                    tbl_d.pg[i]    = fill_page;
                end
            end
        end
    end

    // lookup sees the table after this cycle's invalidate and fill
    rwc_match #(.ENTRIES(ENTRIES), .TAG_W(SECTOR_W)) u_lk_match (
        .valid(tbl_d.valid),
        .tags (tbl_d.tag),
        .key  (lk_sector),
        .any  (lk_any),
        .idx  (lk_idx)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_req;
        if (lk_req && lk_any) begin
            res_d.hit = 1'b1;
            res_d.blk = tbl_d.blk[lk_idx];
            res_d.pg  = tbl_d.pg[lk_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
            res_q <= '0;
        end else begin
            tbl_q <= tbl_d;
            res_q <= res_d;
        end
    end

    assign lk_valid = res_q.valid;
    assign lk_hit   = res_q.hit;
    assign lk_block = res_q.blk;
    assign lk_page  = res_q.pg;
endmodule

// File: rtl/rwc_cache_chk.sv
module rwc_cache_chk #(
    parameter int SECTOR_W  = 16,
    parameter int PAGE_BITS = 5,
    parameter int BLOCK_W   = 12,
    parameter int ENTRIES   = 8,
    localparam int VB_W     = SECTOR_W - PAGE_BITS
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               lk_req,
    input logic [SECTOR_W-1:0]                lk_sector,
    input logic                               fill_en,
    input logic [SECTOR_W-1:0]                fill_sector,
    input logic [BLOCK_W-1:0]                 fill_block,
    input logic [PAGE_BITS-1:0]               fill_page,
    input logic                               inv_en,
    input logic [VB_W-1:0]                    inv_vblock,
    input logic                               lk_valid,
    input logic                               lk_hit,
    input logic [BLOCK_W-1:0]                 lk_block,
    input logic [PAGE_BITS-1:0]               lk_page,
    input logic [ENTRIES-1:0]                 ent_valid,
    input logic [ENTRIES-1:0][SECTOR_W-1:0]   ent_tag
);
    assert_req_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_block == '0 && lk_page == '0));

    assert_fill_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && fill_en && lk_sector == fill_sector) |=>
        (lk_hit && lk_block == $past(fill_block) && lk_page == $past(fill_page)));

    assert_inval_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && inv_en && lk_sector[SECTOR_W-1:PAGE_BITS] == inv_vblock &&
         !(fill_en && fill_sector == lk_sector)) |=> !lk_hit);

    for (genvar a = 0; a < ENTRIES; a++) begin : g_a
        for (genvar b = a + 1; b < ENTRIES; b++) begin : g_b
            assert_unique_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !(ent_valid[a] && ent_valid[b] && ent_tag[a] == ent_tag[b]));
        end
    end
endmodule

bind rwc_cache rwc_cache_chk #(
    .SECTOR_W(SECTOR_W), .PAGE_BITS(PAGE_BITS), .BLOCK_W(BLOCK_W), .ENTRIES(ENTRIES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_req     (lk_req),
    .lk_sector  (lk_sector),
    .fill_en    (fill_en),
    .fill_sector(fill_sector),
    .fill_block (fill_block),
    .fill_page  (fill_page),
    .inv_en     (inv_en),
    .inv_vblock (inv_vblock),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_block   (lk_block),
    .lk_page    (lk_page),
    .ent_valid  (tbl_q.valid),
    .ent_tag    (tbl_q.tag)
);

// File: tb/rwc_cache_test.sv
`timescale 1ns/1ps
module rwc_cache_test;
    localparam int SW = 16;
    localparam int PB = 5;
    localparam int BW = 12;
    localparam int E  = 8;
    localparam int VW = SW - PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_req = 1'b0;
    logic [SW-1:0] lk_sector = '0;
    logic          fill_en = 1'b0;
    logic [SW-1:0] fill_sector = '0;
    logic [BW-1:0] fill_block = '0;
    logic [PB-1:0] fill_page = '0;
    logic          inv_en = 1'b0;
    logic [VW-1:0] inv_vblock = '0;
    logic          lk_valid, lk_hit;
    logic [BW-1:0] lk_block;
    logic [PB-1:0] lk_page;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference table
    bit          m_v[E];
    bit [SW-1:0] m_t[E];
    bit [BW-1:0] m_b[E];
    bit [PB-1:0] m_p[E];
    int          m_ptr = 0;

    always #2 clk = ~clk;

    rwc_cache #(.SECTOR_W(SW), .PAGE_BITS(PB), .BLOCK_W(BW), .ENTRIES(E)) uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_sector(lk_sector),
        .fill_en(fill_en), .fill_sector(fill_sector), .fill_block(fill_block),
        .fill_page(fill_page), .inv_en(inv_en), .inv_vblock(inv_vblock),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_block(lk_block), .lk_page(lk_page)
    );

    function automatic int model_find(input bit [SW-1:0] s);
        for (int i = 0; i < E; i++) if (m_v[i] && m_t[i] == s) return i;
        return -1;
    endfunction

    task automatic step(input bit rq, input bit [SW-1:0] ls,
                        input bit fe, input bit [SW-1:0] fs, input bit [BW-1:0] fb,
                        input bit [PB-1:0] fp, input bit ie, input bit [VW-1:0] iv,
                        input string req);
        bit          ev, eh;
        bit [BW-1:0] eb;
        bit [PB-1:0] ep;
        int          k;
        lk_req = rq; lk_sector = ls; fill_en = fe; fill_sector = fs;
        fill_block = fb; fill_page = fp; inv_en = ie; inv_vblock = iv;
        if (ie) for (int i = 0; i < E; i++)
            if (m_v[i] && m_t[i][SW-1:PB] == iv) m_v[i] = 0;
        if (fe) begin
            k = model_find(fs);
            if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % E; end
            m_v[k] = 1; m_t[k] = fs; m_b[k] = fb; m_p[k] = fp;
        end
        ev = rq; eh = 0; eb = '0; ep = '0;
        if (rq) begin
            k = model_find(ls);
            if (k >= 0) begin eh = 1; eb = m_b[k]; ep = m_p[k]; end
        end
        @(posedge clk); #1;
        vectors++;
        if (lk_valid !== ev || lk_hit !== eh || lk_block !== eb || lk_page !== ep) begin
            errors++;
            $display("FAIL %s sector %0d: got v=%0b h=%0b blk=%0d pg=%0d exp v=%0b h=%0b blk=%0d pg=%0d",
                     req, ls, lk_valid, lk_hit, lk_block, lk_page, ev, eh, eb, ep);
        end
        @(negedge clk);
    endtask

    task automatic look(input bit [SW-1:0] s, input string req);
        step(1, s, 0, '0, '0, '0, 0, '0, req);
    endtask

    task automatic fill(input bit [SW-1:0] s, input bit [BW-1:0] b, input bit [PB-1:0] p,
                        input string req);
        step(0, '0, 1, s, b, p, 0, '0, req);
    endtask

    initial begin
        #700000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < E; i++) m_v[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (lk_valid !== 1'b0 || lk_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b h=%0b exp 0 0", lk_valid, lk_hit);
        end
        @(negedge clk); rst_n = 1'b1;

        look(16'd5, "R1 empty after reset");
        step(0, 16'd5, 0, '0, '0, '0, 0, '0, "R2 idle no valid");
        fill(16'd10, 12'd100, 5'd3, "R3 fill");
        look(16'd10, "R3 hit after fill");
        look(16'd11, "R4 miss unwritten");
        step(1, 16'd20, 1, 16'd20, 12'd77, 5'd9, 0, '0, "R8 same-cycle fill");
        fill(16'd10, 12'd555, 5'd17, "R5 rewrite");
        look(16'd10, "R5 in-place update");
        // eviction: E+1 fresh sectors; first allocated is displaced
        for (int i = 0; i <= E; i++)
            fill(16'(200 + i), 12'(300 + i), 5'(i), "R6 fill");
        look(16'd200, "R6 oldest evicted");
        look(16'(200 + E), "R6 newest held");
        look(16'd201, "R6 second held");
        // invalidate vblock 6 (sectors 192..223)
        step(0, '0, 0, '0, '0, '0, 1, 11'd6, "R7 invalidate");
        look(16'd201, "R7 dropped entry");
        fill(16'd40, 12'd4, 5'd4, "R7 other vblock fill");
        step(0, '0, 0, '0, '0, '0, 1, 11'd6, "R7 invalidate again");
        look(16'd40, "R7 other vblock kept");
        step(1, 16'd40, 0, '0, '0, '0, 1, 11'd1, "R9 invalidate with lookup");
        step(1, 16'd41, 1, 16'd41, 12'd9, 5'd1, 1, 11'd1, "R9 invalidate then fill");
        look(16'd41, "R9 fill after invalidate held");

        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 4000; n++) begin
            bit [SW-1:0] rs = 16'($urandom_range(0, 127));
            bit [SW-1:0] fs = 16'($urandom_range(0, 127));
            bit          same = ($urandom_range(0, 7) == 0);
            step($urandom_range(0, 2) != 0, same ? fs : rs,
                 $urandom_range(0, 1) == 1, fs, 12'($urandom), 5'($urandom),
                 $urandom_range(0, 15) == 0, 11'($urandom_range(0, 3)),
                 "random R3 R5 R6 R7 R8 R9 R10");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule